// File: doc/BRIEF.md
# Brainfuck Multi-Cycle Processor Core

This core runs the eight Brainfuck command characters directly as machine code. Program bytes come from an external read-only memory through a registered address port, and the returned byte is used in the same cycle. Data lives in an internal byte RAM whose address is the data pointer itself. A hardware stack holds the return points of open loops. A byte input port with a valid flag and an acknowledge pulse, and a byte output port with a one-cycle strobe, connect the program to the outside.

Every instruction starts with a three-step fetch: the program counter is advanced, it is copied to the program address register, and the returned byte is decoded into a one-hot vector. Before any branch that depends on a freshly captured value, the controller spends one idle cycle: after the decode, after the zero test and after the input sample. An opening bracket is followed in program memory by a two-byte target, low byte first. The target is the address of the matching closing bracket. When a loop is entered, the loop stack records the bracket's address minus one. This lets the ordinary fetch increment land back on the bracket.

After reset the core spends one cycle per data cell writing zeros into the data RAM. It then fetches from address 0 and runs until it meets a zero program byte or a program counter at or beyond the program length. At that point it raises done and stays halted.

Top module: `bf_core`

## Requirements
- R1: While reset is held, done, out_strobe, in_ack, stack_overflow and stack_underflow are low and prog_addr is 0. After reset, every data cell reads 0. The first instruction is fetched from address 0 in cycle CELLS, counting the first cycle after reset release as cycle 0.
- R2: Only the bytes 0x3E (move right), 0x3C (move left), 0x2B (add one), 0x2D (subtract one), 0x2E (output), 0x2C (input), 0x5B (open loop) and 0x5D (close loop) are instructions. Any other nonzero byte is skipped and changes no cell, pointer or output.
- R3: The data pointer wraps from CELLS-1 to 0 on move right, and from 0 to CELLS-1 on move left.
- R4: Add one and subtract one change the addressed cell modulo 256.
- R5: Output drives out_data with the addressed cell and raises out_strobe for exactly one cycle.
- R6: Input waits while in_valid is low and retries its sample every three cycles. Once a sample sees in_valid high, the core writes the sampled in_data to the addressed cell and pulses in_ack for one cycle, two cycles after that sample.
- R7: When open loop finds a zero cell, the core reads the next two program bytes as a target address, low byte first. Execution continues at the target plus one.
- R8: When open loop finds a nonzero cell, the core pushes the loop's address minus one and continues after the two target bytes. Close loop pops that value into the program counter, so the open loop is tested again.
- R9: The loop stack is STACK_DEPTH entries deep. A push onto a full stack is dropped and sets a sticky stack_overflow. A close loop on an empty stack leaves the program counter alone and sets a sticky stack_underflow.
- R10: A fetched byte of 0x00, or a program counter at or beyond PROG_LEN, halts the core. Done rises three cycles after that fetch begins, stays high, and prog_addr no longer changes.
- R11: Instruction lengths in cycles: a skipped byte takes 4; move, output and close loop take 5; add one, subtract one, open loop on a nonzero cell, and input with data ready each take 7; open loop on a zero cell takes 14. The output strobe is high in the cycle that follows the instruction's fifth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | PC_W | Program memory address (registered) |
| prog_data | input | 8 | Program byte at prog_addr, used in the same cycle |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is available |
| in_ack | output | 1 | One-cycle pulse: input byte consumed |
| out_data | output | 8 | Last output byte |
| out_strobe | output | 1 | One-cycle pulse: out_data is new |
| done | output | 1 | Core has halted |
| stack_overflow | output | 1 | Sticky: push dropped on a full loop stack |
| stack_underflow | output | 1 | Sticky: close loop on an empty loop stack |

## Verification
The case most likely to go wrong is a push onto a full loop stack. The overflow flag must rise in the same cycle as the decision that the loop is entered, and the program counter must still skip the two inline target bytes. The bench provokes this with seventeen nested open loops over a nonzero cell. It expects a set overflow flag together with a clean halt at the following zero byte, because a wrongly executed target byte would change the halt cycle. A second case puts the close-loop pop and the open-loop push of the same loop one instruction apart, over several iterations of an addition loop. There, the strobe cycle and the printed sum must match the reference model exactly.

// File: rtl/bf_pkg.sv
package bf_pkg;

   // controller steps
   typedef enum logic [4:0] {
      S_FINC, S_FADDR, S_FLATCH, S_DEC,
      S_PTR, S_RD, S_ADJ, S_WR, S_OUT,
      S_INL, S_ING, S_IND,
      S_ZL, S_ZG, S_ZD,
      S_AL1, S_AL2, S_AL3, S_AU1, S_AU2, S_AU3, S_JMP,
      S_POP, S_HALT
   } bf_state_e;

   localparam int NUM_OPS = 8;

   // one-hot bit positions, move-right is the most significant bit
   localparam int OPB_RIGHT = 7;
   localparam int OPB_LEFT  = 6;
   localparam int OPB_INC   = 5;
   localparam int OPB_DEC   = 4;
   localparam int OPB_OUT   = 3;
   localparam int OPB_IN    = 2;
   localparam int OPB_OPEN  = 1;
   localparam int OPB_CLOSE = 0;

   // character for one-hot bit b sits in slice [8*b +: 8]
   localparam logic [8*NUM_OPS-1:0] OP_CHARS =
      {8'h3E, 8'h3C, 8'h2B, 8'h2D, 8'h2E, 8'h2C, 8'h5B, 8'h5D};

endpackage

// File: rtl/bf_loop_stack.sv
module bf_loop_stack #(
   parameter int DEPTH = 16,
   parameter int W     = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data,
   output logic         empty,
   output logic         overflow,
   output logic         underflow
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("bf_loop_stack: DEPTH must be at least 2");
   end

   logic [W-1:0]  slots [DEPTH];
   logic [CW-1:0] cnt;
   logic [CW-1:0] top_idx;
   logic          full;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign top_idx  = cnt - CW'(1);
   assign top_data = slots[top_idx[IW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else if (push) begin
         if (full) overflow <= 1'b1;
         else      cnt      <= cnt + CW'(1);
      end else if (pop) begin
         if (empty) underflow <= 1'b1;
         else       cnt       <= cnt - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) slots[cnt[IW-1:0]] <= push_data;
   end

   assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);
   assert_push_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> (top_data == $past(push_data)));

endmodule

// File: rtl/bf_cell_store.sv
module bf_cell_store #(
   parameter int CELLS = 3000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_up,
   input  logic       step_down,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       busy
);
   localparam int              PW   = $clog2(CELLS);
   localparam logic [PW-1:0]   LAST = PW'(CELLS - 1);

   if (CELLS < 2) begin : g_bad_cells
      $error("bf_cell_store: CELLS must be at least 2");
   end

   logic [7:0]    ram [CELLS];
   logic [PW-1:0] ptr;
   logic [PW-1:0] clr_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         clr_idx <= '0;
         busy    <= 1'b1;
      end else if (busy) begin
         if (clr_idx == LAST) busy <= 1'b0;
         else                 clr_idx <= clr_idx + PW'(1);
      end else if (step_up) begin
         ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
      end else if (step_down) begin
         ptr <= (ptr == '0) ? LAST : ptr - PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (busy)       ram[clr_idx] <= 8'h00;
      else if (wr_en) ram[ptr]     <= wr_data;
   end

   assign rd_data = ram[ptr];

   assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
   assert_ptr_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && step_up && ptr == LAST) |=> (ptr == '0));
   assert_ptr_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && step_down && ptr == '0) |=> (ptr == LAST));

endmodule

// File: rtl/bf_core.sv
module bf_core
   import bf_pkg::*;
#(
   parameter int PC_W        = 12,
   parameter int PROG_LEN    = 4096,
   parameter int CELLS       = 3000,
   parameter int STACK_DEPTH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] prog_addr,
   input  logic [7:0]      prog_data,
   input  logic [7:0]      in_data,
   input  logic            in_valid,
   output logic            in_ack,
   output logic [7:0]      out_data,
   output logic            out_strobe,
   output logic            done,
   output logic            stack_overflow,
   output logic            stack_underflow
);
   localparam logic [PC_W:0] LEN_X = (PC_W + 1)'(PROG_LEN);

   if (PROG_LEN < 1 || PROG_LEN > (1 << PC_W)) begin : g_bad_len
      $error("bf_core: PROG_LEN must lie in 1 .. 2**PC_W");
   end
   if (PC_W < 2 || PC_W > 16) begin : g_bad_pcw
      $error("bf_core: PC_W must lie in 2 .. 16");
   end

   bf_state_e       st;
   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] addr_q;
   logic [7:0]      ir;
   logic [7:0]      dec_vec;
   logic [7:0]      rmw;
   logic [7:0]      lo_q, hi_q;
   logic [15:0]     tgt;
   logic            zflag;
   logic            in_flag;
   logic [7:0]      in_byte;
   logic [7:0]      out_q;
   logic            strobe_q;

   logic            step_up, step_down, wr_en;
   logic [7:0]      wr_data, cell_rd;
   logic            clr_busy;
   logic            push, pop, stk_empty;
   logic [PC_W-1:0] stk_top;

   // one-hot decode of the raw program byte
   for (genvar b = 0; b < NUM_OPS; b++) begin : g_dec
      assign dec_vec[b] = (prog_data == OP_CHARS[8*b +: 8]);
   end

   assign tgt = {hi_q, lo_q};

   always_comb begin
      step_up   = (st == S_PTR) && ir[OPB_RIGHT];
      step_down = (st == S_PTR) && ir[OPB_LEFT];
      wr_en     = (st == S_WR) || ((st == S_IND) && in_flag);
      wr_data   = (st == S_WR) ? rmw : in_byte;
      push      = (st == S_ZD) && !zflag;
      pop       = (st == S_POP);
   end

   bf_cell_store #(.CELLS(CELLS)) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_up   (step_up),
      .step_down (step_down),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (cell_rd),
      .busy      (clr_busy)
   );

   bf_loop_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (pc - PC_W'(1)),
      .top_data  (stk_top),
      .empty     (stk_empty),
      .overflow  (stack_overflow),
      .underflow (stack_underflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_FINC;
         pc       <= '1;
         addr_q   <= '0;
         ir       <= '0;
         rmw      <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         zflag    <= 1'b0;
         in_flag  <= 1'b0;
         in_byte  <= '0;
         out_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         unique case (st)
            S_FINC: if (!clr_busy) begin
               pc <= pc + PC_W'(1);
               st <= S_FADDR;
            end
            S_FADDR: begin
               addr_q <= pc;
               st     <= S_FLATCH;
            end
            S_FLATCH: begin
               if (prog_data == 8'h00 || {1'b0, pc} >= LEN_X) st <= S_HALT;
               else begin
                  ir <= dec_vec;
                  st <= S_DEC;
               end
            end
            S_DEC: begin
               if (ir[OPB_RIGHT] || ir[OPB_LEFT])   st <= S_PTR;
               else if (ir[OPB_INC] || ir[OPB_DEC]) st <= S_RD;
               else if (ir[OPB_OUT])                st <= S_OUT;
               else if (ir[OPB_IN])                 st <= S_INL;
               else if (ir[OPB_OPEN])               st <= S_ZL;
               else if (ir[OPB_CLOSE])              st <= S_POP;
               else                                 st <= S_FINC;
            end
            S_PTR: st <= S_FINC;
            S_RD: begin
               rmw <= cell_rd;
               st  <= S_ADJ;
            end
            S_ADJ: begin
               rmw <= ir[OPB_INC] ? rmw + 8'd1 : rmw - 8'd1;
               st  <= S_WR;
            end
            S_WR: st <= S_FINC;
            S_OUT: begin
               out_q    <= cell_rd;
               strobe_q <= 1'b1;
               st       <= S_FINC;
            end
            S_INL: begin
               in_flag <= in_valid;
               in_byte <= in_data;
               st      <= S_ING;
            end
            S_ING: st <= S_IND;
            S_IND: st <= in_flag ? S_FINC : S_INL;
            S_ZL: begin
               zflag <= (cell_rd == 8'h00);
               st    <= S_ZG;
            end
            S_ZG: st <= S_ZD;
            S_ZD: begin
               if (zflag) st <= S_AL1;
               else begin
                  pc <= pc + PC_W'(2);
                  st <= S_FINC;
               end
            end
            S_AL1: begin pc <= pc + PC_W'(1); st <= S_AL2; end
            S_AL2: begin addr_q <= pc;        st <= S_AL3; end
            S_AL3: begin lo_q <= prog_data;   st <= S_AU1; end
            S_AU1: begin pc <= pc + PC_W'(1); st <= S_AU2; end
            S_AU2: begin addr_q <= pc;        st <= S_AU3; end
            S_AU3: begin hi_q <= prog_data;   st <= S_JMP; end
            S_JMP: begin
               pc <= PC_W'(tgt);
               st <= S_FINC;
            end
            S_POP: begin
               if (!stk_empty) pc <= stk_top;
               st <= S_FINC;
            end
            S_HALT: st <= S_HALT;
            default: st <= S_HALT;
         endcase
      end
   end

   assign prog_addr  = addr_q;
   assign out_data   = out_q;
   assign out_strobe = strobe_q;
   assign done       = (st == S_HALT);
   assign in_ack     = (st == S_IND) && in_flag;

   assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe |=> !out_strobe);
   assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack |=> !in_ack);
   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(prog_addr)));
   assert_no_write_when_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!wr_en && !push && !pop));

endmodule

// File: tb/bf_core_tb.sv
`timescale 1ns/1ps
module bf_core_tb;
   localparam int PC_W  = 12;
   localparam int PLEN  = 256;
   localparam int CELLS = 64;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [PC_W-1:0] prog_addr;
   logic [7:0] prog_data, in_data, out_data;
   logic in_valid, in_ack, out_strobe, done, ovf, udf;
   logic [7:0] rom [256];

   assign prog_data = (prog_addr < PC_W'(256)) ? rom[prog_addr[7:0]] : 8'h00;

   bf_core #(.PC_W(PC_W), .PROG_LEN(PLEN), .CELLS(CELLS), .STACK_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
      .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
      .out_data(out_data), .out_strobe(out_strobe), .done(done),
      .stack_overflow(ovf), .stack_underflow(udf)
   );

   int checks = 0;
   int fails = 0;
   int in_q[$];
   int in_idx;
   int st_t[$];
   int st_v[$];
   int ack_t[$];
   int done_t;
   bit m_ovf, m_udf;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // place program text, then fill open-loop targets with matching close address
   task automatic load(string s);
      int opens[$];
      for (int i = 0; i < 256; i++) rom[i] = (i < s.len()) ? s[i] : 8'h00;
      for (int i = 0; i < 256; i++) begin
         if (rom[i] == 8'h5B) opens.push_back(i);
         else if (rom[i] == 8'h5D && opens.size() > 0) begin
            int o;
            o = opens.pop_back();
            rom[o+1] = i[7:0];
            rom[o+2] = 8'(i >> 8);
         end
      end
   endtask

   // behavioural reference: instruction-level interpreter with cycle costs
   task automatic model(int gate);
      int t, pc, ptr, idx, c, b;
      int cells[CELLS];
      int stk[$];
      t = CELLS; pc = 0; ptr = 0; idx = 0;
      st_t.delete(); st_v.delete(); ack_t.delete();
      m_ovf = 0; m_udf = 0;
      foreach (cells[i]) cells[i] = 0;
      forever begin
         if (pc >= PLEN || rom[pc] == 8'h00) begin done_t = t + 3; break; end
         if (t > 150000) begin done_t = t; break; end
         b = rom[pc];
         case (b)
            8'h3E: begin ptr = (ptr + 1) % CELLS; t += 5; pc++; end
            8'h3C: begin ptr = (ptr == 0) ? CELLS - 1 : ptr - 1; t += 5; pc++; end
            8'h2B: begin cells[ptr] = (cells[ptr] + 1) & 255; t += 7; pc++; end
            8'h2D: begin cells[ptr] = (cells[ptr] + 255) & 255; t += 7; pc++; end
            8'h2E: begin st_t.push_back(t + 5); st_v.push_back(cells[ptr]); t += 5; pc++; end
            8'h2C: begin
               c = t + 4;
               while (!(idx < in_q.size() && c >= gate)) c += 3;
               ack_t.push_back(c + 2);
               cells[ptr] = in_q[idx] & 255;
               idx++;
               t = c + 3; pc++;
            end
            8'h5B: begin
               if (cells[ptr] == 0) begin
                  pc = (rom[pc+1] | (rom[pc+2] << 8)) + 1;
                  t += 14;
               end else begin
                  if (stk.size() < DEPTH) stk.push_back(pc - 1);
                  else m_ovf = 1;
                  pc += 3; t += 7;
               end
            end
            8'h5D: begin
               if (stk.size() > 0) pc = stk.pop_back() + 1;
               else begin m_udf = 1; pc++; end
               t += 5;
            end
            default: begin t += 4; pc++; end
         endcase
      end
   endtask

   task automatic drive(int k, int gate);
      in_valid = (in_idx < in_q.size()) && (k >= gate);
      in_data  = in_valid ? 8'(in_q[in_idx]) : 8'h00;
   endtask

   task automatic run(string name, int gate);
      int si, ai;
      bit es, ea;
      model(gate);
      rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_idx = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1", {name, " done in reset"}, done, 0);
      chk(out_strobe == 1'b0 && in_ack == 1'b0, "R1", {name, " pulses in reset"}, out_strobe, 0);
      chk(ovf == 1'b0 && udf == 1'b0, "R1", {name, " flags in reset"}, ovf | udf, 0);
      chk(prog_addr == '0, "R1", {name, " prog_addr in reset"}, prog_addr, 0);
      rst_n = 1'b1;
      drive(0, gate);
      si = 0; ai = 0;
      for (int k = 1; k <= done_t + 6; k++) begin
         @(negedge clk);
         es = (si < st_t.size()) && (st_t[si] == k);
         chk(out_strobe == es, "R11", {name, " strobe cycle"}, out_strobe, es);
         if (es) begin
            chk(out_data == 8'(st_v[si]), "R5", {name, " output byte"}, out_data, st_v[si]);
            si++;
         end
         ea = (ai < ack_t.size()) && (ack_t[ai] == k);
         chk(in_ack == ea, "R6", {name, " ack cycle"}, in_ack, ea);
         if (ea) ai++;
         if (in_ack) in_idx++;
         chk(done == (k >= done_t), "R10", {name, " done"}, done, k >= done_t);
         drive(k, gate);
      end
      chk(si == st_t.size(), "R5", {name, " output count"}, si, st_t.size());
      chk(ovf == m_ovf, "R9", {name, " overflow flag"}, ovf, m_ovf);
      chk(udf == m_udf, "R9", {name, " underflow flag"}, udf, m_udf);
   endtask

   initial begin
      string s;
      in_valid = 1'b0; in_data = 8'h00;
      // R2 non-command bytes skipped; R1 cells start at zero
      load("a+b+ +#.>.");
      run("skip", 0);
      // R3 pointer wrap both ways
      load("<+++>++<.>.");
      run("wrap", 0);
      // R4 cell arithmetic modulo 256
      load("-.+.");
      run("mod256", 0);
      // R6 input stall with late valid, R5 echo
      in_q = '{8'h41, 8'h7F};
      load(",.,.");
      run("stall", CELLS + 40);
      // R7 R8 addition loop
      in_q = '{5, 7};
      load(",>,<[@@->+<]>.");
      run("addloop", 0);
      in_q = '{};
      // R7 zero cell skips the body
      load("[@@+++].+[@@-].");
      run("skipbody", 0);
      // R9 overflow: seventeen nested loops over a nonzero cell
      s = "+";
      for (int i = 0; i < DEPTH + 1; i++) s = {s, "[@@"};
      load(s);
      run("overflow", 0);
      // R9 underflow: close loop with empty stack
      load("]+.");
      run("underflow", 0);
      // R10 halt when counter reaches the program length
      s = "+.";
      for (int i = 2; i < PLEN; i++) s = {s, "z"};
      load(s);
      run("length", 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(190000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule